// File: doc/BRIEF.md
# Bit-Split Multi-Pattern Byte Matcher

This block scans a byte stream against a small group of patterns and reports, one cycle after each byte, which patterns end at that byte. The byte-wide pattern automaton is not stored directly. Four small automata run side by side, and each one steps on a 2-bit slice of the byte, so every state has four successors instead of 256. Each small automaton has its own transition table and, for each of its states, a partial match vector with one bit per pattern. A pattern counts as found only when all four automata flag it, and the bitwise AND of their four vectors decides this.

The tables are loaded through a shared configuration port. A tile-select field on that port routes each write to one of the four tiles. A write fills one whole state entry: its four next-state pointers and its partial match vector. A flush input returns all four automata to their start state at a packet boundary, so that no match can run across two packets. Building the tables from the patterns, and packet framing, happen outside this block.

Top module: `bitsplit_rule_matcher`

## Requirements
- R1: Tile 0 steps on byte bits 7:6, tile 1 on bits 5:4, tile 2 on bits 3:2 and tile 3 on bits 1:0. A byte that differs from a pattern character in any one slice does not complete that pattern.
- R2: Each bit of `out_match` is the AND of the matching bit in the four tiles' partial match vectors for the states the tiles enter on that byte.
- R3: One byte is accepted per cycle while `in_valid` is high. Every occurrence of every pattern is reported, overlapping occurrences included.
- R4: With he, she, his, hers loaded on vector bits 3, 2, 1 and 0, the stream h, x, h, e yields 0000, 0000, 0000 and then 1000.
- R5: `out_valid` equals `in_valid` of the previous cycle, and `out_match` carries the result for the byte presented in that cycle. `out_match` is 0000 whenever `out_valid` is low.
- R6: `flush` puts all four tiles in state 0. If `in_valid` is high in the same cycle, that byte is processed from state 0 as the first byte of a new packet.
- R7: When `cfg_we` is high, the entry `cfg_state` of the tile chosen by `cfg_tile` is written. The pointer for slice value s is `cfg_next[4*s+3:4*s]`, and the entry's partial match vector is `cfg_pmv`. The other tiles are left unchanged.
- R8: After reset, `out_valid` is 0, `out_match` is 0000, and every table entry is zero, so nothing matches until the tables are loaded.
- R9: Cycles with `in_valid` low leave every tile in its current state, so a pattern split by idle cycles is still found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A payload byte is present this cycle |
| in_byte | input | 8 | Payload byte |
| flush | input | 1 | Return all tiles to state 0 (packet boundary) |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_tile | input | 2 | Tile that receives the write |
| cfg_state | input | 4 | State entry being written |
| cfg_next | input | 16 | Four next-state pointers, 4 bits per slice value |
| cfg_pmv | input | 4 | Partial match vector of the entry |
| out_valid | output | 1 | `out_match` is meaningful this cycle |
| out_match | output | 4 | Full match vector, one bit per pattern |

## Verification
The assertions take for granted that `in_valid`, `flush` and `cfg_we` are never unknown after reset. They also take for granted that every loaded pointer names one of the 16 table entries. The bench changes all inputs at the falling edge. It writes the tables only in cycles where no byte is presented, and it builds every entry from the patterns themselves, so every pointer stays in range. The expected vectors come from a direct suffix comparison of the stream seen since the last flush. Sweeps put every byte value after "h" and after "sh", and a long pseudo-random stream mixes near-miss characters with idle cycles and flushes.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    // Byte slicing shared by the tiles and the top level
    localparam int BYTE_W     = 8;
    localparam int SLICE_W    = 2;
    localparam int NUM_TILES  = BYTE_W / SLICE_W;
    localparam int NUM_SYMS   = 1 << SLICE_W;
    localparam int TILE_SEL_W = $clog2(NUM_TILES);

    // Tile t takes the t-th slice counted from the most significant end
    function automatic logic [SLICE_W-1:0] slice_of(input logic [BYTE_W-1:0] b, input int t);
        return b[BYTE_W-1-SLICE_W*t -: SLICE_W];
    endfunction
endpackage

// File: rtl/bsm_tile.sv
module bsm_tile
    import bsm_pkg::*;
#(
    parameter int NUM_STATES   = 16,
    parameter int NUM_PATTERNS = 4,
    parameter int STATE_W      = $clog2(NUM_STATES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step,
    input  logic                            flush,
    input  logic [SLICE_W-1:0]              slice,
    input  logic                            cfg_we,
    input  logic [STATE_W-1:0]              cfg_state,
    input  logic [NUM_SYMS*STATE_W-1:0]     cfg_next,
    input  logic [NUM_PATTERNS-1:0]         cfg_pmv,
    output logic [NUM_PATTERNS-1:0]         pmv_o
);
    typedef struct packed {
        logic [NUM_SYMS-1:0][STATE_W-1:0] next;
        logic [NUM_PATTERNS-1:0]          pmv;
    } entry_t;

    typedef struct packed {
        logic [STATE_W-1:0]           state;
        entry_t [NUM_STATES-1:0]      tbl;
    } regs_t;

    regs_t              r_d, r_q;
    logic [STATE_W-1:0] base_d, state_q;

    assign state_q = r_q.state;

    always_comb begin
        r_d    = r_q;
        base_d = flush ? '0 : r_q.state;
        if (step) begin
            r_d.state = r_q.tbl[base_d].next[slice];
        end else begin
            r_d.state = base_d;
        end
        if (cfg_we && (int'(cfg_state) < NUM_STATES)) begin
            r_d.tbl[cfg_state].next = cfg_next;
            r_d.tbl[cfg_state].pmv  = cfg_pmv;
        end
        pmv_o = r_q.tbl[r_d.state].pmv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R6
    flush_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !step) |=> (state_q == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !flush) |=> $stable(state_q));
endmodule

// File: rtl/bsm_combine.sv
module bsm_combine
    import bsm_pkg::*;
#(
    parameter int NUM_PATTERNS = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   valid_i,
    input  logic [NUM_TILES-1:0][NUM_PATTERNS-1:0] pmv_i,
    output logic                                   valid_o,
    output logic [NUM_PATTERNS-1:0]                match_o
);
    typedef struct packed {
        logic                    valid;
        logic [NUM_PATTERNS-1:0] match;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d.valid = valid_i;
        r_d.match = valid_i ? '1 : '0;
        for (int t = 0; t < NUM_TILES; t++) begin
            r_d.match = r_d.match & pmv_i[t];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid_o = r_q.valid;
    assign match_o = r_q.match;

    // R5
    valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (valid_o == $past(valid_i)));

    // R5
    quiet_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (match_o == '0));

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_and
        // R2
        all_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i |=> ((match_o & ~$past(pmv_i[t])) == '0));
    end
endmodule

// File: rtl/bitsplit_rule_matcher.sv
module bitsplit_rule_matcher
    import bsm_pkg::*;
#(
    parameter int NUM_STATES   = 16,
    parameter int NUM_PATTERNS = 4,
    parameter int STATE_W      = $clog2(NUM_STATES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [7:0]                     in_byte,
    input  logic                           flush,
    input  logic                           cfg_we,
    input  logic [1:0]                     cfg_tile,
    input  logic [STATE_W-1:0]             cfg_state,
    input  logic [4*STATE_W-1:0]           cfg_next,
    input  logic [NUM_PATTERNS-1:0]        cfg_pmv,
    output logic                           out_valid,
    output logic [NUM_PATTERNS-1:0]        out_match
);
    logic [NUM_TILES-1:0][NUM_PATTERNS-1:0] pmv_all;

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        logic tile_we;
        assign tile_we = cfg_we && (cfg_tile == TILE_SEL_W'(t));

        bsm_tile #(
            .NUM_STATES   (NUM_STATES),
            .NUM_PATTERNS (NUM_PATTERNS),
            .STATE_W      (STATE_W)
        ) u_tile (
            .clk       (clk),
            .rst_n     (rst_n),
            .step      (in_valid),
            .flush     (flush),
            .slice     (slice_of(in_byte, t)),
            .cfg_we    (tile_we),
            .cfg_state (cfg_state),
            .cfg_next  (cfg_next),
            .cfg_pmv   (cfg_pmv),
            .pmv_o     (pmv_all[t])
        );
    end

    bsm_combine #(
        .NUM_PATTERNS (NUM_PATTERNS)
    ) u_combine (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .pmv_i   (pmv_all),
        .valid_o (out_valid),
        .match_o (out_match)
    );
endmodule

// File: tb/sim_bitsplit_rule_matcher.sv
`timescale 1ns/1ps
module sim_bitsplit_rule_matcher;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [7:0]  in_byte = 0;
    logic        flush = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_tile = 0;
    logic [3:0]  cfg_state = 0;
    logic [15:0] cfg_next = 0;
    logic [3:0]  cfg_pmv = 0;
    logic        out_valid;
    logic [3:0]  out_match;

    always #2 clk = ~clk;

    bitsplit_rule_matcher u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .flush(flush),
        .cfg_we(cfg_we), .cfg_tile(cfg_tile), .cfg_state(cfg_state), .cfg_next(cfg_next),
        .cfg_pmv(cfg_pmv), .out_valid(out_valid), .out_match(out_match)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // pattern group: index k maps to vector bit 3-k
    logic [7:0] pat [4][4];
    int         plen [4];

    // golden history, newest byte at index 0
    logic [7:0] hist [4];
    int         hlen = 0;

    bit         have_pend = 0;
    bit         exp_v;
    logic [3:0] exp_m;
    string      pend_tag;

    function automatic logic [3:0] model();
        logic [3:0] m = '0;
        for (int k = 0; k < 4; k++) begin
            bit ok = (plen[k] <= hlen);
            for (int j = 0; j < plen[k] && ok; j++)
                if (pat[k][plen[k]-1-j] != hist[j]) ok = 0;
            m[3-k] = ok;
        end
        return m;
    endfunction

    task automatic cyc(input bit v, input logic [7:0] b, input bit f, input bit we,
                       input int tile, input int st, input logic [15:0] nx, input logic [3:0] pm,
                       input bit ovr, input logic [3:0] om, input string tag);
        @(negedge clk);
        if (have_pend) begin
            checks++;
            if (out_valid !== exp_v || out_match !== exp_m) begin
                fails++;
                $display("FAIL %s: valid=%0b match=%b expected valid=%0b match=%b",
                         pend_tag, out_valid, out_match, exp_v, exp_m);
            end
        end
        in_valid  = v;  in_byte = b;  flush = f;
        cfg_we    = we; cfg_tile = 2'(tile); cfg_state = 4'(st);
        cfg_next  = nx; cfg_pmv = pm;
        if (f) hlen = 0;
        if (v) begin
            for (int j = 3; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = b;
            if (hlen < 4) hlen++;
        end
        exp_v     = v;
        exp_m     = v ? (ovr ? om : model()) : 4'b0000;
        have_pend = 1;
        pend_tag  = tag;
    endtask

    task automatic byte_in(input logic [7:0] b, input string tag);
        cyc(1, b, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic cfg(input int tile, input int st, input logic [15:0] nx, input logic [3:0] pm);
        cyc(0, 0, 0, 1, tile, st, nx, pm, 0, 0, "R7 cfg");
    endtask

    function automatic bit is_suffix(input logic [9:0] s, input int ls, input logic [9:0] w, input int lw);
        if (ls > lw) return 0;
        for (int j = 0; j < ls; j++)
            if (s[2*j +: 2] != w[2*(lw-ls+j) +: 2]) return 0;
        return 1;
    endfunction

    function automatic logic [1:0] proj(input logic [7:0] b, input int t);
        return b[7-2*t -: 2];
    endfunction

    // Build a 2-bit automaton for tile t from the projected patterns and load it
    task automatic load_tile(input int t);
        logic [9:0] sseq [16];
        int         slen [16];
        int         ns = 1;
        sseq[0] = '0; slen[0] = 0;
        for (int k = 0; k < 4; k++) begin
            logic [9:0] seq = '0;
            for (int l = 1; l <= plen[k]; l++) begin
                bit found = 0;
                seq[2*(l-1) +: 2] = proj(pat[k][l-1], t);
                for (int i = 0; i < ns; i++)
                    if (slen[i] == l && sseq[i] == seq) found = 1;
                if (!found) begin sseq[ns] = seq; slen[ns] = l; ns++; end
            end
        end
        for (int i = 0; i < 16; i++) begin
            logic [15:0] nx = '0;
            logic [3:0]  pm = '0;
            if (i < ns) begin
                for (int c = 0; c < 4; c++) begin
                    logic [9:0] w = sseq[i];
                    int best = 0;
                    w[2*slen[i] +: 2] = 2'(c);
                    for (int j = 0; j < ns; j++)
                        if (slen[j] > slen[best] && is_suffix(sseq[j], slen[j], w, slen[i] + 1)) best = j;
                    nx[4*c +: 4] = 4'(best);
                end
                for (int k = 0; k < 4; k++) begin
                    logic [9:0] ps = '0;
                    for (int l = 0; l < plen[k]; l++) ps[2*l +: 2] = proj(pat[k][l], t);
                    if (is_suffix(ps, plen[k], sseq[i], slen[i])) pm[3-k] = 1'b1;
                end
            end
            cfg(t, i, nx, pm);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  alpha [8];
        logic [15:0] lfsr = 16'hACE1;
        pat[0][0] = "h"; pat[0][1] = "e"; plen[0] = 2;
        pat[1][0] = "s"; pat[1][1] = "h"; pat[1][2] = "e"; plen[1] = 3;
        pat[2][0] = "h"; pat[2][1] = "i"; pat[2][2] = "s"; plen[2] = 3;
        pat[3][0] = "h"; pat[3][1] = "e"; pat[3][2] = "r"; pat[3][3] = "s"; plen[3] = 4;
        alpha[0] = "h"; alpha[1] = "e"; alpha[2] = "s"; alpha[3] = "i";
        alpha[4] = "r"; alpha[5] = "x"; alpha[6] = 8'h28; alpha[7] = 8'h66;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state at the ports
        checks++;
        if (out_valid !== 1'b0 || out_match !== 4'b0000) begin
            fails++;
            $display("FAIL R8 reset: valid=%0b match=%b expected valid=0 match=0000", out_valid, out_match);
        end
        rst_n = 1;

        // R8: empty tables match nothing
        cyc(1, "h", 0, 0, 0, 0, 0, 0, 1, 4'b0000, "R8 empty table");
        cyc(1, "e", 0, 0, 0, 0, 0, 0, 1, 4'b0000, "R8 empty table");

        // R7: three tiles report all patterns from state 0, tile 3 still empty
        for (int t = 0; t < 3; t++) cfg(t, 0, 16'h0000, 4'b1111);
        cyc(1, "h", 0, 0, 0, 0, 0, 0, 1, 4'b0000, "R7 tile 3 untouched");
        cfg(3, 0, 16'h0000, 4'b1111);
        cyc(1, "x", 0, 0, 0, 0, 0, 0, 1, 4'b1111, "R7 tile 3 written");

        for (int t = 0; t < 4; t++) load_tile(t);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R6 flush idle");

        // R4 reference stream
        byte_in("h", "R4"); byte_in("x", "R4"); byte_in("h", "R4"); byte_in("e", "R4");
        // R3 overlapping occurrences
        byte_in("r", "R3"); byte_in("s", "R3"); byte_in("h", "R3"); byte_in("e", "R3");
        byte_in("h", "R3"); byte_in("i", "R3"); byte_in("s", "R3");
        // R9 gaps inside a pattern
        byte_in("s", "R9"); idle("R9 idle"); byte_in("h", "R9"); idle("R9 idle"); idle("R9 idle");
        byte_in("e", "R9");
        // R6 flush with a byte: no match across the boundary
        byte_in("s", "R6"); byte_in("h", "R6");
        cyc(1, "e", 1, 0, 0, 0, 0, 0, 0, 0, "R6 flush with byte");
        byte_in("h", "R6"); cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R6 flush idle");
        byte_in("e", "R6");

        // R1/R2 sweeps: every byte value after "h" and after "sh"
        for (int b = 0; b < 256; b++) begin
            cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R1 flush");
            byte_in("h", "R1");
            byte_in(8'(b), "R1 byte after h");
            cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 flush");
            byte_in("s", "R2"); byte_in("h", "R2");
            byte_in(8'(b), "R2 byte after sh");
        end

        // R3 long mixed stream with gaps and flushes
        for (int n = 0; n < 4000; n++) begin
            bit v, f;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = (lfsr[9:8] != 2'b00);
            f = (lfsr[15:10] == 6'h3F);
            cyc(v, alpha[lfsr[2:0]], f, 0, 0, 0, 0, 0, 0, 0, "R3 random stream");
        end
        idle("R5 tail");
        idle("R5 tail");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule